// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block runs transfers on a classic multiplexed external memory bus on behalf of a one-cycle command interface. The bus has three parts. One 8-bit shared port carries the low address byte first and the data after it. A separate port carries the high address byte. Three strobes complete it: an active-high address-latch enable and active-low read and write strobes. An external 8-bit latch, clocked by the falling address-latch strobe, holds the low address byte while the shared port carries data.

A command is either a transfer or a page operation. A transfer can be a read or a write. It uses either a full 16-bit address, or an 8-bit low address whose high byte comes from an internal page register. Page operations load, increment or decrement the page register. Each page operation takes half the time of a transfer and does not touch the bus. The length of every bus phase is a parameter. The defaults are 6 clocks for each of the four transfer phases, which gives 24 clocks per transfer, and 12 clocks per page operation.

The controller has seven states. S_IDLE waits for a command. S_ADDR drives the low byte with the latch strobe high. S_LATCH keeps the low byte and drops the latch strobe. S_SETUP drives write data or releases the port. S_STROBE holds the read or write strobe low. S_PAGE times a page operation. S_DONE gives the done pulse. The transitions are:
- S_IDLE goes to S_ADDR when a transfer is accepted.
- S_IDLE goes to S_PAGE when a page operation is accepted.
- Each timed state moves on when its phase timer expires: S_ADDR to S_LATCH, S_LATCH to S_SETUP, S_SETUP to S_STROBE, S_STROBE to S_DONE, and S_PAGE to S_DONE.
- S_DONE always returns to S_IDLE.

Top module: `xbus_master`

## Requirements
- R1: After reset, ale is 0, rd_n and wr_n are 1, bus_oe is 0, and busy and done are 0. The page register is 0, so a page-mode access right after reset puts 0x00 on addr_hi.
- R2: A command is accepted on a clock edge where cmd_valid is 1 and the block is idle. busy is 1 from that edge until the end of the done cycle. done is high for exactly one cycle.
- R3: A read (cmd_op 0 uses the full address; cmd_op 2 uses page mode) runs its phases in this order:
  - The shared port is driven with the low address byte and ale is 1, for ALE_CLKS cycles.
  - ale falls and addr_hi takes the high byte; the low byte stays driven for LATCH_CLKS cycles.
  - bus_oe falls for SETUP_CLKS cycles.
  - rd_n is 0 for STROBE_CLKS cycles.
- R4: A write (cmd_op 1 uses the full address; cmd_op 3 uses page mode) has the same address phases as a read. The shared port then carries the write data for SETUP_CLKS cycles. wr_n is 0 for STROBE_CLKS cycles with the data still driven, and the data is still driven in the done cycle.
- R5: done rises ALE_CLKS+LATCH_CLKS+SETUP_CLKS+STROBE_CLKS cycles after the accept edge for a transfer (24 by default), and PAGE_CLKS cycles after it for a page operation (12 by default).
- R6: rdata takes the value on bus_in in the last cycle that rd_n is low, and holds it until the next read completes.
- R7: In page mode (cmd_op bit 1 set on a transfer), the high address byte is the page register value at acceptance and the low byte is cmd_addr[7:0]. In full mode the address is cmd_addr[15:0].
- R8: Page operations:
  - cmd_op 4 loads the page register from cmd_wdata[7:0].
  - cmd_op 5 increments it modulo 256.
  - cmd_op 6 decrements it modulo 256.
  - None of them asserts ale, rd_n, wr_n or bus_oe.
- R9: rd_n and wr_n are never low together. ale is low in the cycle before either strobe falls and while either strobe is low. bus_oe is low whenever rd_n is low.
- R10: addr_hi changes only at the end of the latch-enable phase of a transfer. It holds its value while idle and through the latch-enable phase of the next transfer.
- R11: While idle, all strobes are inactive and the port is released. cmd_op 7 is never accepted. A command presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R3, R4, R8, R11) |
| cmd_addr | input | ADDR_W | Transfer address; bits [7:0] only in page mode |
| cmd_wdata | input | DATA_W | Write data, or the page load value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read result |
| bus_out | output | DATA_W | Shared port output value |
| bus_oe | output | 1 | Shared port output enable |
| bus_in | input | DATA_W | Shared port input value |
| addr_hi | output | ADDR_W-DATA_W | High address port |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
For a command accepted at edge k, the latch-enable phase is visible from the sample after edge k. The latch phase is visible from the sample after edge k+6, setup from k+12 and the strobe from k+18. done is seen at k+24 for a transfer and at k+12 for a page operation. The driver records the cycle counter at the sample after acceptance, and the scoreboard monitor subtracts that stamp when done appears, so each latency is checked exactly rather than waited for. Directed tests sample bus outputs at those fixed offsets, all on falling clock edges. Read data is compared at the done sample against a bench memory model that answers on bus_in while rd_n is low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        OP_RD      = 3'd0,
        OP_WR      = 3'd1,
        OP_RD_PG   = 3'd2,
        OP_WR_PG   = 3'd3,
        OP_PG_LOAD = 3'd4,
        OP_PG_INC  = 3'd5,
        OP_PG_DEC  = 3'd6,
        OP_NONE    = 3'd7
    } xbus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_LATCH,
        S_SETUP,
        S_STROBE,
        S_PAGE,
        S_DONE
    } xbus_state_e;

    typedef enum logic [1:0] {
        PG_HOLD,
        PG_LOAD,
        PG_INC,
        PG_DEC
    } page_act_e;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/xbus_page_reg.sv
module xbus_page_reg
    import xbus_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          apply,
    input  page_act_e     act,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] page
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
        end else if (apply) begin
            unique case (act)
                PG_LOAD: page <= load_val;
                PG_INC:  page <= page + PW'(1);
                PG_DEC:  page <= page - PW'(1);
                default: page <= page;
            endcase
        end
    end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int ALE_CLKS    = 6,
    parameter int LATCH_CLKS  = 6,
    parameter int SETUP_CLKS  = 6,
    parameter int STROBE_CLKS = 6,
    parameter int PAGE_CLKS   = 12,
    parameter int CW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic          tmr_expired,
    output logic          accept,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_len,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          drive_addr,
    output logic          drive_data,
    output logic          hi_load,
    output logic          rd_capture,
    output logic          page_apply,
    output logic          busy,
    output logic          done
);

    xbus_state_e state_q, state_d;
    logic        wr_q;

    assign accept = (state_q == S_IDLE) && cmd_valid && (cmd_op != OP_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q <= cmd_op[0] && !cmd_op[2];
            end
        end
    end

    // Transitions and phase timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (!cmd_op[2]) begin
                        state_d = S_ADDR;
                        tmr_len = CW'(ALE_CLKS);
                    end else begin
                        state_d = S_PAGE;
                        tmr_len = CW'(PAGE_CLKS);
                    end
                end
            end
            S_ADDR: begin
                if (tmr_expired) begin
                    state_d  = S_LATCH;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(LATCH_CLKS);
                end
            end
            S_LATCH: begin
                if (tmr_expired) begin
                    state_d  = S_SETUP;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(SETUP_CLKS);
                end
            end
            S_SETUP: begin
                if (tmr_expired) begin
                    state_d  = S_STROBE;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(STROBE_CLKS);
                end
            end
            S_STROBE: begin
                if (tmr_expired) begin
                    state_d = S_DONE;
                end
            end
            S_PAGE: begin
                if (tmr_expired) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        drive_addr = 1'b0;
        drive_data = 1'b0;
        hi_load    = 1'b0;
        rd_capture = 1'b0;
        page_apply = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_ADDR: begin
                ale        = 1'b1;
                drive_addr = 1'b1;
                hi_load    = tmr_expired;
            end
            S_LATCH: begin
                drive_addr = 1'b1;
            end
            S_SETUP: begin
                drive_data = wr_q;
            end
            S_STROBE: begin
                drive_data = wr_q;
                wr_n       = !wr_q;
                rd_n       = wr_q;
                rd_capture = !wr_q && tmr_expired;
            end
            S_PAGE: begin
                page_apply = tmr_expired;
            end
            S_DONE: begin
                drive_data = wr_q;
                done       = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ALE_CLKS    = 6,
    parameter int LATCH_CLKS  = 6,
    parameter int SETUP_CLKS  = 6,
    parameter int STROBE_CLKS = 6,
    parameter int PAGE_CLKS   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [DATA_W-1:0]        cmd_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        bus_out,
    output logic                     bus_oe,
    input  logic [DATA_W-1:0]        bus_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int MAX_PH = max_of2(max_of2(max_of2(ALE_CLKS, LATCH_CLKS),
                                            max_of2(SETUP_CLKS, STROBE_CLKS)),
                                    PAGE_CLKS);
    localparam int CW     = $clog2(MAX_PH + 1);

    logic            accept, tmr_load, tmr_expired;
    logic [CW-1:0]   tmr_len;
    logic            drive_addr, drive_data, hi_load, rd_capture, page_apply;
    logic [HI_W-1:0] page;

    logic [DATA_W-1:0] lo_q, wdata_q, rdata_q;
    logic [HI_W-1:0]   hi_pend_q, hi_q;
    page_act_e         act_q, act_d;

    xbus_fsm #(
        .ALE_CLKS   (ALE_CLKS),
        .LATCH_CLKS (LATCH_CLKS),
        .SETUP_CLKS (SETUP_CLKS),
        .STROBE_CLKS(STROBE_CLKS),
        .PAGE_CLKS  (PAGE_CLKS),
        .CW         (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .tmr_expired(tmr_expired),
        .accept     (accept),
        .tmr_load   (tmr_load),
        .tmr_len    (tmr_len),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .hi_load    (hi_load),
        .rd_capture (rd_capture),
        .page_apply (page_apply),
        .busy       (busy),
        .done       (done)
    );

    xbus_phase_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expired(tmr_expired)
    );

    xbus_page_reg #(.PW(HI_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (page_apply),
        .act     (act_q),
        .load_val(HI_W'(cmd_wdata_q_for_page(wdata_q))),
        .page    (page)
    );

    function automatic logic [DATA_W-1:0] cmd_wdata_q_for_page(input logic [DATA_W-1:0] v);
        return v;
    endfunction

    always_comb begin
        unique case (cmd_op)
            OP_PG_LOAD: act_d = PG_LOAD;
            OP_PG_INC:  act_d = PG_INC;
            OP_PG_DEC:  act_d = PG_DEC;
            default:    act_d = PG_HOLD;
        endcase
    end

    // Command capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            wdata_q   <= '0;
            hi_pend_q <= '0;
            act_q     <= PG_HOLD;
        end else if (accept) begin
            lo_q      <= cmd_addr[DATA_W-1:0];
            wdata_q   <= cmd_wdata;
            hi_pend_q <= cmd_op[1] ? page : cmd_addr[ADDR_W-1:DATA_W];
            act_q     <= act_d;
        end
    end

    // High address port and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (hi_load) begin
                hi_q <= hi_pend_q;
            end
            if (rd_capture) begin
                rdata_q <= bus_in;
            end
        end
    end

    assign addr_hi = hi_q;
    assign rdata   = rdata_q;
    assign bus_oe  = drive_addr || drive_data;
    assign bus_out = drive_data ? wdata_q : (drive_addr ? lo_q : '0);

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            bus_oe,
    input logic            busy,
    input logic            done,
    input logic [HI_W-1:0] addr_hi
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R9
    ale_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> (!ale && $past(!ale)));

    // R9
    ale_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);

    // R9
    read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_oe);

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(addr_hi));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ale && !bus_oe));

endmodule

bind xbus_master xbus_master_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bus_oe (bus_oe),
    .busy   (busy),
    .done   (done),
    .addr_hi(addr_hi)
);

// File: tb/xbus_master_tb.sv
module xbus_master_tb;

    localparam int XFER_LAT = 24;
    localparam int PAGE_LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_wdata;
    logic        busy, done;
    logic [7:0]  rdata, bus_out, bus_in, addr_hi;
    logic        bus_oe, ale, rd_n, wr_n;

    always #2 clk = ~clk;

    xbus_master u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_wdata(cmd_wdata),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .bus_in   (bus_in),
        .addr_hi  (addr_hi),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    typedef struct {
        int          kind;   // 0 page op, 1 read, 2 write
        logic [15:0] addr;
        logic [7:0]  data;
        int          lat;
        int          t0;
        string       req;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          proto_bad = 0;
    logic [7:0]  pg_model = 8'h00;
    logic [7:0]  dev[int];
    logic [7:0]  shadow[int];
    logic [7:0]  ext_latch = 8'h00;
    logic [15:0] obs_rd_addr = 16'h0;
    logic [15:0] obs_wr_addr = 16'h0;
    logic [7:0]  obs_wr_data = 8'h0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] seed(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] dev_rd(input logic [15:0] a);
        if (dev.exists(int'(a))) return dev[int'(a)];
        return seed(a);
    endfunction

    function automatic logic [7:0] sh_rd(input logic [15:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return seed(a);
    endfunction

    // External device model: address latch and memory
    always @(negedge ale) ext_latch = bus_out;
    always @(posedge rd_n) if (rst_n) obs_rd_addr = {addr_hi, ext_latch};
    always @(posedge wr_n) begin
        if (rst_n) begin
            obs_wr_addr = {addr_hi, ext_latch};
            obs_wr_data = bus_out;
            dev[int'({addr_hi, ext_latch})] = bus_out;
        end
    end
    always @(negedge clk) bus_in <= (rst_n && !rd_n) ? dev_rd({addr_hi, ext_latch}) : 8'hA5;

    // Bus rules observed every cycle (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rd_n && bus_oe) proto_bad++;
            if (!rd_n && !wr_n) proto_bad++;
            if (ale && (!rd_n || !wr_n)) proto_bad++;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin : mon
        item_t it;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "done with nothing pending", 1, 0);
            end else begin
                it = sb.pop_front();
                chk(cyc - it.t0 == it.lat, "R5", {it.req, " done latency"}, cyc - it.t0, it.lat);
                if (it.kind == 1) begin
                    chk(rdata == it.data, "R6", {it.req, " read data"}, rdata, it.data);
                    chk(obs_rd_addr == it.addr, "R7", {it.req, " read address"}, obs_rd_addr, it.addr);
                end else if (it.kind == 2) begin
                    chk(obs_wr_addr == it.addr, "R7", {it.req, " write address"}, obs_wr_addr, it.addr);
                    chk(obs_wr_data == it.data, "R4", {it.req, " write data"}, obs_wr_data, it.data);
                end
            end
        end
    end

    // Driver: returns at the sample right after the accept edge
    task automatic issue(input logic [2:0] op, input logic [15:0] a,
                         input logic [7:0] wd, input string req);
        item_t it;
        logic [15:0] ea;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        ea = op[1] ? {pg_model, a[7:0]} : a;
        it.t0 = cyc; it.req = req; it.addr = ea; it.data = wd;
        it.kind = 0; it.lat = XFER_LAT;
        case (op)
            3'd0, 3'd2: begin it.kind = 1; it.data = sh_rd(ea); end
            3'd1, 3'd3: begin it.kind = 2; shadow[int'(ea)] = wd; end
            3'd4: begin pg_model = wd; it.lat = PAGE_LAT; end
            3'd5: begin pg_model = pg_model + 8'd1; it.lat = PAGE_LAT; end
            3'd6: begin pg_model = pg_model - 8'd1; it.lat = PAGE_LAT; end
            default: ;
        endcase
        sb.push_back(it);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = 16'h0; cmd_wdata = 8'h0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(ale == 1'b0 && rd_n && wr_n, "R1", "strobes after reset", {ale, rd_n, wr_n}, 3'b011);
        chk(!bus_oe && !busy && !done, "R1", "oe/busy/done after reset", {bus_oe, busy, done}, 0);
        rst_n = 1'b1;

        // R1 / R7: page register starts at zero
        issue(3'd2, 16'h0040, 8'h00, "R1 page read after reset");
        wait_idle();
        chk(addr_hi == 8'h00, "R1", "page after reset on addr_hi", addr_hi, 8'h00);

        // R4 / R6: full-address write then read back
        issue(3'd1, 16'h1234, 8'hC3, "R4 write");
        wait_idle();
        issue(3'd0, 16'h1234, 8'h00, "R6 readback");
        wait_idle();

        // R10 hold between accesses
        issue(3'd0, 16'hAB10, 8'h00, "R3 read");
        wait_idle();
        repeat (3) @(negedge clk);
        chk(addr_hi == 8'hAB, "R10", "addr_hi held while idle", addr_hi, 8'hAB);

        // R3 directed read phases, R11 ignore while busy
        issue(3'd0, 16'h5520, 8'h00, "R3 directed read");
        chk(ale && bus_oe && bus_out == 8'h20 && rd_n, "R3", "latch-enable phase", {ale, bus_oe, bus_out}, {2'b11, 8'h20});
        chk(addr_hi == 8'hAB, "R10", "addr_hi in latch-enable phase", addr_hi, 8'hAB);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 16'h0F0F; cmd_wdata = 8'h11;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ale && bus_oe && bus_out == 8'h20, "R3", "latch phase port", {ale, bus_oe, bus_out}, {2'b01, 8'h20});
        chk(addr_hi == 8'h55, "R3", "high byte driven", addr_hi, 8'h55);
        repeat (6) @(negedge clk);
        chk(!bus_oe && rd_n, "R3", "setup phase released", {bus_oe, rd_n}, 2'b01);
        repeat (6) @(negedge clk);
        chk(!rd_n && wr_n && !bus_oe, "R3", "read strobe low", {rd_n, wr_n, bus_oe}, 3'b010);
        repeat (5) @(negedge clk);
        chk(!rd_n, "R3", "read strobe last cycle", rd_n, 0);
        @(negedge clk);
        chk(rd_n && done, "R2", "done as strobe rises", {rd_n, done}, 2'b11);
        @(negedge clk);
        chk(!busy && !done, "R2", "busy released after done", {busy, done}, 0);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R11", "command while busy ignored", sb.size(), 0);

        // R4 directed write phases
        issue(3'd1, 16'h0102, 8'h7E, "R4 directed write");
        repeat (12) @(negedge clk);
        chk(bus_oe && bus_out == 8'h7E && wr_n, "R4", "setup data driven", {bus_oe, bus_out, wr_n}, {1'b1, 8'h7E, 1'b1});
        repeat (6) @(negedge clk);
        chk(!wr_n && rd_n && bus_out == 8'h7E, "R4", "write strobe low", {wr_n, rd_n, bus_out}, {2'b01, 8'h7E});
        repeat (6) @(negedge clk);
        chk(wr_n && bus_oe && bus_out == 8'h7E, "R4", "data held in done", {wr_n, bus_oe, bus_out}, {2'b11, 8'h7E});
        wait_idle();

        // R8 page operations
        issue(3'd4, 16'h0000, 8'h12, "R8 page load");
        repeat (5) @(negedge clk);
        chk(busy && !ale && rd_n && wr_n && !bus_oe, "R8", "page op bus quiet",
            {busy, ale, rd_n, wr_n, bus_oe}, 5'b10110);
        wait_idle();
        issue(3'd2, 16'h0034, 8'h00, "R7 page read 0x1234");
        wait_idle();
        issue(3'd5, 16'h0000, 8'h00, "R8 page inc");
        wait_idle();
        issue(3'd3, 16'h0005, 8'h99, "R7 page write 0x1305");
        wait_idle();
        issue(3'd0, 16'h1305, 8'h00, "R7 full read 0x1305");
        wait_idle();
        issue(3'd6, 16'h0000, 8'h00, "R8 page dec");
        wait_idle();
        issue(3'd6, 16'h0000, 8'h00, "R8 page dec");
        wait_idle();
        issue(3'd2, 16'h0034, 8'h00, "R7 page read 0x1134");
        wait_idle();
        issue(3'd4, 16'h0000, 8'h00, "R8 page load zero");
        wait_idle();
        issue(3'd6, 16'h0000, 8'h00, "R8 page dec wrap");
        wait_idle();
        issue(3'd3, 16'h0001, 8'h44, "R8 write after wrap");
        wait_idle();
        issue(3'd0, 16'hFF01, 8'h00, "R8 read 0xFF01");
        wait_idle();
        issue(3'd4, 16'h0000, 8'hFF, "R8 page load FF");
        wait_idle();
        issue(3'd5, 16'h0000, 8'h00, "R8 page inc wrap");
        wait_idle();
        issue(3'd2, 16'h0007, 8'h00, "R8 page read 0x0007");
        wait_idle();

        // R11 reserved op
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd7; cmd_addr = 16'h2222; cmd_wdata = 8'h22;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy && !ale && !bus_oe, "R11", "reserved op not accepted", {busy, ale, bus_oe}, 0);
        repeat (30) @(negedge clk);

        chk(sb.size() == 0, "R2", "all commands completed", sb.size(), 0);
        chk(proto_bad == 0, "R9", "strobe/port rule violations", proto_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule